// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the oversampling tick of a serial receiver and transmitter from the system clock. Software sets a divisor with a 16-bit whole part and a 6-bit fraction. The tick period averages `whole + fraction/64` system clocks. To get that average, each period is either `whole` or `whole + 1` clocks long. A 6-bit phase accumulator decides which periods receive the extra clock.

A second stage counts oversample ticks and emits one strobe per serial bit. When the speed select is low it strobes every sixteenth tick. When the speed select is high it strobes every eighth tick. Software computes the divisor as system clock over (oversample factor × baud rate). For example, 20 MHz at 115200 baud with 16x oversampling gives a whole part of 10 and a fraction of 54.

Writes to the two divisor parts land in staging registers. They change nothing until a separate commit strobe arrives. That strobe copies both staged parts into the working divisor at the same time.

Top module: `baud_tick_gen`

## Requirements
- R1: Out of reset, the staged and working divisors are zero. Both `os_tick` and `bit_strobe` stay low.
- R2: A write on `int_wr` or `frac_wr` does not change the tick output until `commit` is pulsed. On the clock edge where `commit` is high, both staged parts become the working divisor.
- R3: Every tick period is either W or W+1 clocks, where W is the working whole part and F is the working fraction.
  - A 6-bit accumulator starts at 0 and adds F once per period.
  - A period is W+1 clocks exactly when that period's addition carries out of bit 5.
  - Any 64 consecutive periods therefore total 64·W + F clocks.
- R4: While the working whole part is 0, no tick is produced.
- R5: `os_tick` is high for a single clock per period. With W=1 and F=0 it is high on every clock.
- R6: `bit_strobe` fires together with every sixteenth `os_tick` when `hs_sel`=0, and with every eighth `os_tick` when `hs_sel`=1. Counting restarts at the strobe.
- R7: While `enable` is low, neither output pulses. The period counter, the accumulator and the tick count are cleared, so a new enable starts again with the accumulator at 0.
- R8: W=10, F=54 yields 694 clocks over 64 tick periods. That is the 20 MHz / 115200 baud / 16x setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; low clears its counters |
| hs_sel | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| int_wr | input | 1 | Stage `int_wdata` as the whole part |
| int_wdata | input | 16 | Whole part of the divisor |
| frac_wr | input | 1 | Stage `frac_wdata` as the fraction |
| frac_wdata | input | 6 | Fraction of the divisor, in 1/64 units |
| commit | input | 1 | Copies the staged divisor into the working divisor |
| os_tick | output | 1 | Oversample tick, one clock wide |
| bit_strobe | output | 1 | One pulse per serial bit, coincident with a tick |

## Verification
The bench builds the block with its default 16-bit whole part and 6-bit fraction. At this width the whole part can be as small as 1, so back-to-back ticks and periods of one or two clocks are reachable. The same build covers the 10/54 baud setting and fractions such as 32 and 63, whose carry patterns can be predicted exactly.

For each setting, the bench predicts every one of 64 consecutive periods from the accumulator rule. It also counts ticks between bit strobes at both speed selections.

// File: rtl/btg_pkg.sv
package btg_pkg;
    localparam int unsigned DIV_INT_W  = 16;
    localparam int unsigned DIV_FRAC_W = 6;
    localparam int unsigned OS_LO      = 16;
    localparam int unsigned OS_HI      = 8;

    function automatic int unsigned os_factor(input logic hs);
        return hs ? OS_HI : OS_LO;
    endfunction
endpackage

// File: rtl/btg_div_regs.sv
module btg_div_regs #(
    parameter int unsigned INT_W  = btg_pkg::DIV_INT_W,
    parameter int unsigned FRAC_W = btg_pkg::DIV_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_wr,
    input  logic [INT_W-1:0]  int_wdata,
    input  logic              frac_wr,
    input  logic [FRAC_W-1:0] frac_wdata,
    input  logic              commit,
    output logic [INT_W-1:0]  act_int,
    output logic [FRAC_W-1:0] act_frac
);
    typedef struct packed {
        logic [INT_W-1:0]  stg_int;
        logic [FRAC_W-1:0] stg_frac;
        logic [INT_W-1:0]  wrk_int;
        logic [FRAC_W-1:0] wrk_frac;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (int_wr)  r_d.stg_int  = int_wdata;
        if (frac_wr) r_d.stg_frac = frac_wdata;
        if (commit) begin
            r_d.wrk_int  = r_q.stg_int;
            r_d.wrk_frac = r_q.stg_frac;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign act_int  = r_q.wrk_int;
    assign act_frac = r_q.wrk_frac;

    // R2: the working divisor moves only on a commit
    assert_hold_until_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_int) && $stable(act_frac)));
endmodule

// File: rtl/btg_frac_div.sv
module btg_frac_div #(
    parameter int unsigned INT_W  = btg_pkg::DIV_INT_W,
    parameter int unsigned FRAC_W = btg_pkg::DIV_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);
    typedef struct packed {
        logic [INT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
        logic              tick;
    } st_t;

    st_t s_d, s_q;
    logic [FRAC_W:0]  sum;
    logic             carry;
    logic [INT_W-1:0] limit;
    logic             run;

    always_comb begin
        sum   = {1'b0, s_q.acc} + {1'b0, div_frac};
        carry = sum[FRAC_W];
        limit = div_int - {{(INT_W-1){1'b0}}, 1'b1} + {{(INT_W-1){1'b0}}, carry};
        run   = enable && (div_int != '0);
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
            s_d.acc = '0;
        end else if (s_q.cnt >= limit) begin
            s_d.tick = 1'b1;
            s_d.cnt  = '0;
            s_d.acc  = sum[FRAC_W-1:0];
        end else begin
            s_d.cnt = s_q.cnt + {{(INT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;

    // R4 / R7: a zero whole part or a low enable silences the next clock
    assert_no_tick_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || div_int == '0) |=> !tick);
    // R5: with a period of at least two clocks the tick is one clock wide
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_int > 1 && $stable(div_int)) |=> !tick);
    // R3: the position inside a period never passes the whole part
    assert_period_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(div_int)) |-> (s_q.cnt <= div_int));
endmodule

// File: rtl/btg_bit_div.sv
module btg_bit_div #(
    parameter int unsigned OS_MAX = btg_pkg::OS_LO,
    localparam int unsigned CW = $clog2(OS_MAX)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic hs_sel,
    input  logic tick,
    output logic strobe
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } bst_t;

    bst_t b_d, b_q;
    logic [CW-1:0] last;
    logic          wrap;

    always_comb begin
        last = CW'(btg_pkg::os_factor(hs_sel) - 1);
        wrap = tick && (b_q.cnt >= last);
        b_d  = b_q;
        if (!enable)    b_d.cnt = '0;
        else if (wrap)  b_d.cnt = '0;
        else if (tick)  b_d.cnt = b_q.cnt + {{(CW-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign strobe = enable && wrap;

    // R6: two bit strobes never fall on adjacent clocks
    assert_strobe_spaced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
    // R7: with enable low no bit strobe is produced
    assert_strobe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !strobe);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int unsigned INT_W  = btg_pkg::DIV_INT_W,
    parameter int unsigned FRAC_W = btg_pkg::DIV_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              hs_sel,
    input  logic              int_wr,
    input  logic [INT_W-1:0]  int_wdata,
    input  logic              frac_wr,
    input  logic [FRAC_W-1:0] frac_wdata,
    input  logic              commit,
    output logic              os_tick,
    output logic              bit_strobe
);
    logic [INT_W-1:0]  act_int;
    logic [FRAC_W-1:0] act_frac;

    btg_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .int_wr(int_wr), .int_wdata(int_wdata),
        .frac_wr(frac_wr), .frac_wdata(frac_wdata),
        .commit(commit), .act_int(act_int), .act_frac(act_frac)
    );

    btg_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) frac_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .div_int(act_int), .div_frac(act_frac), .tick(os_tick)
    );

    btg_bit_div #(.OS_MAX(btg_pkg::OS_LO)) bit_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .hs_sel(hs_sel),
        .tick(os_tick), .strobe(bit_strobe)
    );

    // R6: every bit strobe sits on a tick
    assert_strobe_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> os_tick);
    // R1: right after reset nothing pulses
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!os_tick && !bit_strobe));
endmodule

// File: tb/baud_tick_gen_tb_top.sv
`timescale 1ns/1ps
module baud_tick_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        hs_sel = 1'b0;
    logic        int_wr = 1'b0;
    logic [15:0] int_wdata = '0;
    logic        frac_wr = 1'b0;
    logic [5:0]  frac_wdata = '0;
    logic        commit = 1'b0;
    logic        os_tick, bit_strobe;

    always #2.5 clk = ~clk;

    baud_tick_gen dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .hs_sel(hs_sel),
        .int_wr(int_wr), .int_wdata(int_wdata), .frac_wr(frac_wr),
        .frac_wdata(frac_wdata), .commit(commit),
        .os_tick(os_tick), .bit_strobe(bit_strobe)
    );

    int checks = 0;
    int errors = 0;
    int expq[$];
    bit arm = 1'b0;
    bit have_last = 1'b0;
    int cyc = 0;
    int last_t = 0;
    int act_sum = 0;
    int tick_total = 0;
    int ticks_since = 0;
    bit bit_chk = 1'b0;
    int bit_exp = 16;
    int bit_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: pops predicted periods and compares measured ones
    always @(negedge clk) begin
        cyc++;
        if (!arm) have_last = 1'b0;
        if (!enable) ticks_since = 0;
        if (rst_n && os_tick) begin
            tick_total++;
            ticks_since++;
            if (arm && have_last && expq.size() > 0) begin
                int e;
                e = expq.pop_front();
                act_sum += cyc - last_t;
                chk((cyc - last_t) == e, "R3 period", cyc - last_t, e);
            end
            last_t = cyc;
            have_last = 1'b1;
        end
        if (rst_n && bit_strobe) begin
            if (bit_chk) begin
                bit_seen++;
                chk(ticks_since == bit_exp, "R6 ticks per bit", ticks_since, bit_exp);
            end
            ticks_since = 0;
        end
    end

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic write_div(input int w, input int f);
        @(negedge clk);
        int_wr = 1'b1; int_wdata = w[15:0];
        frac_wr = 1'b1; frac_wdata = f[5:0];
        @(negedge clk);
        int_wr = 1'b0; frac_wr = 1'b0;
    endtask

    task automatic do_commit();
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    int mark;

    // driver: predicts periods 2..65 from the accumulator rule
    task automatic run_seq(input int w, input int f, input bit hs, input string req);
        int acc;
        int waited;
        enable = 1'b0;
        arm = 1'b0;
        cycles(3);
        write_div(w, f);
        do_commit();
        hs_sel = hs;
        bit_exp = hs ? 8 : 16;
        acc = 0;
        for (int p = 1; p <= 65; p++) begin
            int s;
            s = acc + f;
            if (p >= 2) expq.push_back(w + ((s >= 64) ? 1 : 0));
            acc = s % 64;
        end
        act_sum = 0;
        bit_seen = 0;
        bit_chk = 1'b1;
        arm = 1'b1;
        @(negedge clk);
        enable = 1'b1;
        waited = 0;
        while (expq.size() != 0 && waited < 50000) begin
            @(negedge clk);
            waited++;
        end
        chk(expq.size() == 0, {req, " all periods seen"}, expq.size(), 0);
        chk(act_sum == 64 * w + f, {req, " R3 64-period total"}, act_sum, 64 * w + f);
        chk(bit_seen >= 3, "R6 strobes seen", bit_seen, 3);
        bit_chk = 1'b0;
        expq.delete();
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cycles(2);
        chk(os_tick == 1'b0, "R1 tick in reset", os_tick, 0);
        chk(bit_strobe == 1'b0, "R1 strobe in reset", bit_strobe, 0);
        rst_n = 1'b1;
        enable = 1'b1;
        mark = tick_total;
        cycles(100);
        chk(tick_total == mark, "R1 R4 no ticks with zero divisor", tick_total - mark, 0);

        // R2: staged only
        write_div(2, 0);
        mark = tick_total;
        cycles(100);
        chk(tick_total == mark, "R2 staged value idle", tick_total - mark, 0);
        do_commit();
        cycles(50);
        chk(tick_total - mark >= 20, "R2 commit starts ticks", tick_total - mark, 20);

        // R7: enable low silences ticks
        enable = 1'b0;
        cycles(1);
        mark = tick_total;
        cycles(100);
        chk(tick_total == mark, "R7 disabled", tick_total - mark, 0);

        run_seq(10, 54, 1'b0, "R8");
        run_seq(3, 32, 1'b1, "R3 half");
        run_seq(1, 0, 1'b1, "R5 every clock");
        run_seq(1, 63, 1'b0, "R3 near full");
        run_seq(2, 0, 1'b0, "R5 two clocks");
        run_seq(3, 32, 1'b1, "R7 restart");

        // R4: committing a zero whole part while running stops ticks
        write_div(0, 17);
        do_commit();
        cycles(2);
        mark = tick_total;
        cycles(100);
        chk(tick_total == mark, "R4 zero whole part", tick_total - mark, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule